// File: doc/BRIEF.md
# Cascadable Interrupt Controller

This block collects 32 interrupt sources and presents one request to the processor. Each source has its own programmable active level and its own choice of edge or level detection. A detected event sets a sticky bit in a status register. The status bits are combined with an enable register, and the lowest-numbered pending source is reported as an index with a valid flag. A registered request output is also driven. Software acknowledges a source by writing a one to its status bit.

Register access is a plain port: a word offset, write data, a write strobe, and read data that is decoded combinationally. All raw inputs pass through a two-flop synchroniser. A second controller's request output can be cascaded into source 30 of this controller through a dedicated input.

Top module: `icu_ctrl`

## Requirements
- R1: Source n occupies bit (31 - n) of `src_i` and of every per-source register, so source 0 is the most significant bit.
- R2: Pending is the bitwise AND of status and enable. A source that has status set but enable clear never raises `irq_o` or `irq_vld_o`.
- R3: `irq_idx_o` is the lowest-numbered pending source and `irq_vld_o` is high when any source is pending. With nothing pending, the index reads 0.
- R4: A write to offset 0 clears each status bit where the write data is one and leaves the other bits unchanged. A cleared level source whose input is still active is set again on the same edge.
- R5: Polarity bit one makes a source active high or rising. Polarity bit zero makes it active low or falling.
- R6: Trigger bit zero selects level detection, which sets status on every clock the input is active. Trigger bit one selects edge detection, which sets status once on the active transition. An edge-set status bit holds until cleared, and a steadily held input does not set it again.
- R7: A change on `src_i` is visible in status after the third rising clock edge. It is visible on `irq_o`, `irq_vld_o` and the index after the fourth edge. `irq_o` is high exactly when something was pending one cycle earlier.
- R8: With cascading enabled (the default), source 30 (mask 0x00000002) is driven by `cascade_i`, and `src_i[1]` is ignored.
- R9: Word offsets are status 0, enable 2, polarity 4, trigger 5 and pending 6. Offset 6 is read-only and reads valid in bit 31 and the index in bits 4:0. Writes to offset 6 or to unmapped offsets change nothing. Unmapped offsets read 0.
- R10: Reset clears status, enable, trigger and the outputs, and sets polarity to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw asynchronous interrupt sources, source n on bit 31-n |
| cascade_i | input | 1 | Request from a secondary controller, routed to source 30 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| irq_o | output | 1 | Registered request toward the processor |
| irq_vld_o | output | 1 | Registered flag that the index is valid |
| irq_idx_o | output | 5 | Registered number of the winning source |

## Verification
The controller is driven with several input patterns:
- A single active-high level source, used to pin down bit mapping and the three-edge and four-edge latency.
- Three simultaneous sources, used to separate correct priority from a reversed scan.
- A disabled but set source, which tells gating apart from raw status.
- An active-low source at rest, which exposes a polarity inversion fault.
- A one-cycle pulse and a held input in edge mode, which separate sticky edge capture from level re-assertion.
- A cascade request alongside a stray `src_i[1]`, which shows which input feeds source 30.

A behavioural model also checks every output and the addressed register on every cycle.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int NSRC   = 32;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int ADDR_W = 3;

    typedef logic [NSRC-1:0] srcvec_t;

    typedef enum logic [ADDR_W-1:0] {
        OFF_STAT = 3'd0,
        OFF_EN   = 3'd2,
        OFF_POL  = 3'd4,
        OFF_TRIG = 3'd5,
        OFF_PICK = 3'd6
    } reg_off_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Lowest source number wins; source n lives at bit NSRC-1-n.
    function automatic pick_t pick_first(srcvec_t v);
        pick_t r;
        r = '0;
        for (int b = 0; b < NSRC; b++) begin
            if (v[b]) begin
                r.valid = 1'b1;
                r.idx   = IDX_W'(NSRC - 1 - b);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/icu_capture.sv
module icu_capture (
    input  logic clk,
    input  logic rst,
    input  logic din_i,
    input  logic pol_i,
    input  logic trig_i,
    input  logic clr_i,
    output logic stat_o
);
    logic active, prev_q, set_w;

    assign active = ~(din_i ^ pol_i);
    assign set_w  = trig_i ? (active & ~prev_q) : active;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_o <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            stat_o <= (stat_o & ~clr_i) | set_w;
            prev_q <= active;
        end
    end

    // Status never drops unless software cleared it.
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        $past(stat_o && !clr_i) |-> stat_o);

    // A clear with no active input leaves the bit low.
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $past(clr_i && !active) |-> !stat_o);

    // Level mode: an active input always sets status.
    assert_level_set_R6: assert property (@(posedge clk) disable iff (rst)
        $past(active && !trig_i) |-> stat_o);
endmodule

// File: rtl/icu_prio.sv
module icu_prio
    import icu_pkg::*;
(
    input  srcvec_t vec_i,
    output pick_t   pick_o
);
    always_comb pick_o = pick_first(vec_i);
endmodule

// File: rtl/icu_ctrl.sv
module icu_ctrl
    import icu_pkg::*;
#(
    parameter bit CASCADE_EN  = 1'b1,
    parameter int CASCADE_SRC = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic              cascade_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    output logic [NSRC-1:0]   rdata_o,
    output logic              irq_o,
    output logic              irq_vld_o,
    output logic [IDX_W-1:0]  irq_idx_o
);
    localparam int CASC_BIT = NSRC - 1 - CASCADE_SRC;

    srcvec_t raw, synced, stat, clr, en_q, pol_q, trig_q, pend;
    pick_t   pick;

    generate
        if (CASCADE_EN) begin : g_casc
            always_comb begin
                raw           = src_i;
                raw[CASC_BIT] = cascade_i;
            end
        end else begin : g_nocasc
            logic unused_casc;
            assign unused_casc = cascade_i;
            assign raw = src_i;
        end
    endgenerate

    icu_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(raw), .q_o(synced)
    );

    assign clr = (wr_en_i && addr_i == OFF_STAT) ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '1;
            trig_q <= '0;
        end else if (wr_en_i) begin
            case (addr_i)
                OFF_EN:   en_q   <= wdata_i;
                OFF_POL:  pol_q  <= wdata_i;
                OFF_TRIG: trig_q <= wdata_i;
                default:  ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            icu_capture u_cap (
                .clk(clk), .rst(rst), .din_i(synced[g]), .pol_i(pol_q[g]),
                .trig_i(trig_q[g]), .clr_i(clr[g]), .stat_o(stat[g])
            );
        end
    endgenerate

    assign pend = stat & en_q;

    icu_prio u_prio (.vec_i(pend), .pick_o(pick));

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o     <= 1'b0;
            irq_vld_o <= 1'b0;
            irq_idx_o <= '0;
        end else begin
            irq_o     <= |pend;
            irq_vld_o <= pick.valid;
            irq_idx_o <= pick.idx;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFF_STAT: rdata_o = stat;
            OFF_EN:   rdata_o = en_q;
            OFF_POL:  rdata_o = pol_q;
            OFF_TRIG: rdata_o = trig_q;
            OFF_PICK: begin
                rdata_o[NSRC-1]    = irq_vld_o;
                rdata_o[IDX_W-1:0] = irq_idx_o;
            end
            default:  rdata_o = '0;
        endcase
    end

    assert_reset_vals_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && trig_q == '0 && pol_q == '1 && !irq_o));

    assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $past((stat & en_q) == '0) |-> !irq_vld_o);

    always @(posedge clk) begin
        if (!rst && pick.valid) begin
            assert_first_set_R3: assert (pend[NSRC-1-int'(pick.idx)] &&
                ((pend >> (NSRC - int'(pick.idx))) == '0));
        end
    end
endmodule

// File: tb/icu_ctrl_bench.sv
module icu_ctrl_bench;
    import icu_pkg::*;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic        casc = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o, irq_vld;
    logic [4:0]  irq_idx;

    always #(PERIOD/2) clk = ~clk;

    icu_ctrl u_icu_ctrl (
        .clk(clk), .rst(rst), .src_i(src), .cascade_i(casc),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq_o), .irq_vld_o(irq_vld), .irq_idx_o(irq_idx)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_s1, m_s2, m_stat, m_en, m_pol, m_trig, m_prev;
    logic [31:0] m_pend, m_act, m_set, m_clr, m_eff;
    logic        m_irq, m_vld;
    logic [4:0]  m_idx;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_stat = 0; m_en = 0; m_pol = '1;
            m_trig = 0; m_prev = 0; m_irq = 0; m_vld = 0; m_idx = 0;
        end else begin
            m_pend = m_stat & m_en;
            m_irq  = (m_pend != 0);
            m_vld  = m_irq;
            m_idx  = 0;
            for (int n = 31; n >= 0; n--) if (m_pend[31-n]) m_idx = 5'(n);
            m_act  = ~(m_s2 ^ m_pol);
            m_set  = 0;
            for (int b = 0; b < 32; b++)
                m_set[b] = m_trig[b] ? (m_act[b] && !m_prev[b]) : m_act[b];
            m_clr  = (wr_en && addr == 3'd0) ? wdata : 32'h0;
            m_stat = (m_stat & ~m_clr) | m_set;
            m_prev = m_act;
            if (wr_en) begin
                if (addr == 3'd2) m_en = wdata;
                if (addr == 3'd4) m_pol = wdata;
                if (addr == 3'd5) m_trig = wdata;
            end
            m_eff    = src;
            m_eff[1] = casc;
            m_s2 = m_s1;
            m_s1 = m_eff;
        end
    end

    function automatic logic [31:0] model_rd(logic [2:0] a);
        case (a)
            3'd0: return m_stat;
            3'd2: return m_en;
            3'd4: return m_pol;
            3'd5: return m_trig;
            3'd6: return {m_vld, 26'b0, m_idx};
            default: return 32'h0;
        endcase
    endfunction

    always begin
        @(negedge clk);
        #1;
        if (!rst && !done) begin
            check("R7 irq_o vs model", {31'b0, irq_o}, {31'b0, m_irq});
            check("R3 valid vs model", {31'b0, irq_vld}, {31'b0, m_vld});
            if (m_vld) check("R3 index vs model", {27'b0, irq_idx}, {27'b0, m_idx});
            check("R9 rdata vs model", rdata, model_rd(addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_check(string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #2;
        check(tag, rdata, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        // R10 reset state
        rd_check("R10 enable reset", 3'd2, 32'h0);
        rd_check("R10 polarity reset", 3'd4, 32'hFFFFFFFF);
        rd_check("R10 trigger reset", 3'd5, 32'h0);
        rd_check("R10 status reset", 3'd0, 32'h0);
        check("R10 irq reset", {31'b0, irq_o}, 32'h0);

        // R1 / R7: source 5 on bit 26, latency
        wr(3'd2, 32'hFFFFFFFF);
        src[26] = 1'b1;
        wait_n(3);
        rd_check("R7 R1 status after 3 edges", 3'd0, 32'h04000000);
        check("R7 irq not yet", {31'b0, irq_o}, 32'h0);
        wait_n(1);
        check("R7 irq after 4 edges", {31'b0, irq_o}, 32'h1);
        rd_check("R1 R9 pick source 5", 3'd6, 32'h80000005);

        // R3: sources 3 and 9 added
        src[22] = 1'b1; src[28] = 1'b1;
        wait_n(4);
        rd_check("R3 lowest wins", 3'd6, 32'h80000003);

        // R4: write-one-to-clear
        src = '0;
        wait_n(3);
        wr(3'd0, 32'h0);
        rd_check("R4 zero write keeps", 3'd0, 32'h14400000);
        wr(3'd0, 32'h10000000);
        rd_check("R4 partial clear", 3'd0, 32'h04400000);
        wr(3'd0, 32'hFFFFFFFF);
        rd_check("R4 full clear", 3'd0, 32'h0);
        wait_n(1);
        check("R4 irq drops", {31'b0, irq_o}, 32'h0);
        src[26] = 1'b1;
        wait_n(4);
        wr(3'd0, 32'h04000000);
        rd_check("R4 level reasserts", 3'd0, 32'h04000000);
        src = '0;
        wait_n(3);
        wr(3'd0, 32'hFFFFFFFF);

        // R2: enable gating
        wr(3'd2, 32'hFBFFFFFF);
        src[26] = 1'b1;
        wait_n(4);
        rd_check("R2 status set while disabled", 3'd0, 32'h04000000);
        check("R2 no irq when disabled", {31'b0, irq_o}, 32'h0);
        src = '0;
        wait_n(3);
        wr(3'd0, 32'hFFFFFFFF);
        wr(3'd2, 32'hFFFFFFFF);

        // R5: active-low source 12 (bit 19) at rest
        wr(3'd4, 32'hFFF7FFFF);
        wait_n(2);
        rd_check("R5 active low pending", 3'd6, 32'h8000000C);
        src[19] = 1'b1;
        wait_n(3);
        wr(3'd0, 32'hFFFFFFFF);
        rd_check("R5 high input inactive", 3'd0, 32'h0);
        src = '0;
        wr(3'd4, 32'hFFFFFFFF);
        wr(3'd0, 32'hFFFFFFFF);

        // R6: edge mode source 20 (bit 11)
        wr(3'd5, 32'h00000800);
        src[11] = 1'b1;
        wait_n(1);
        src[11] = 1'b0;
        wait_n(4);
        rd_check("R6 pulse captured", 3'd6, 32'h80000014);
        wait_n(5);
        rd_check("R6 edge holds", 3'd0, 32'h00000800);
        wr(3'd0, 32'h00000800);
        rd_check("R6 edge cleared", 3'd0, 32'h0);
        src[11] = 1'b1;
        wait_n(4);
        rd_check("R6 held input sets once", 3'd0, 32'h00000800);
        wr(3'd0, 32'h00000800);
        wait_n(3);
        rd_check("R6 held input no reset", 3'd0, 32'h0);
        src = '0;
        wait_n(3);
        wr(3'd5, 32'h0);
        wr(3'd0, 32'hFFFFFFFF);

        // R8: cascade into source 30
        casc = 1'b1;
        wait_n(4);
        rd_check("R8 cascade index", 3'd6, 32'h8000001E);
        rd_check("R8 cascade status", 3'd0, 32'h00000002);
        casc = 1'b0;
        wait_n(3);
        wr(3'd0, 32'hFFFFFFFF);
        src[1] = 1'b1;
        wait_n(4);
        rd_check("R8 src bit ignored", 3'd0, 32'h0);
        check("R8 no irq from src bit", {31'b0, irq_o}, 32'h0);
        src = '0;

        // R9: read-only and unmapped offsets
        wr(3'd6, 32'h12345678);
        rd_check("R9 pick read-only", 3'd6, 32'h0);
        wr(3'd1, 32'hFFFFFFFF);
        rd_check("R9 unmapped reads zero", 3'd1, 32'h0);
        wr(3'd3, 32'h0);
        rd_check("R9 enable untouched", 3'd2, 32'hFFFFFFFF);
        rd_check("R9 offset 7 zero", 3'd7, 32'h0);

        wait_n(2);
        finish_run();
    end
endmodule